// File: doc/BRIEF.md
# Two-Channel Reloadable DMA Controller

This block holds two independent transfer channels that share one memory master port. Each channel waits for a trigger and then moves a single data unit, either a byte or a 16-bit word. The trigger comes from a selectable peripheral request line or from a software request bit. The unit is read from the channel's source address and then written to its destination address. A unit count sets the length of a block. When the count runs out, the channel pulses its interrupt line. It then restores its count, and the address that steps, from reload registers, so the next block repeats without any help from software.

Each channel lets at most one address side advance: the source, the destination, or neither. The CPU programs the channels through a small register port. A write to the fixed-side address is used at once. Writes to the stepping-side address and to the count are held in reload registers until the next reload. A reload happens on underflow or when the channel is enabled again. If both channels are waiting at the same moment, channel 0 takes the bus first.

Top module: `dmac_top`

## Requirements
- R1: After reset the bus request and both interrupt outputs are low, every register reads 0 and both channels are disabled.
- R2: A transfer is a read cycle at the channel's working source (`bus_we`=0) followed by a write cycle at its working destination (`bus_we`=1) carrying the data read. Request, address and direction stay stable until `bus_ack`. The request drops for at least one cycle after the write is acknowledged, before any further transfer.
- R3: Control bits [7:6] choose the stepping side: 0 means both addresses are fixed, 1 means the source steps, 2 means the destination steps. A written 3 is stored and read back as 0. Control bit 5 selects 16-bit units. The stepping address advances by 1 for bytes and by 2 for words, and wraps within 20 bits.
- R4: A block is the count reload value plus one unit. When a unit finishes with the working count at 0, the channel pulses its `irq` bit for one cycle, in the cycle after the write acknowledge. It also reloads the count and the stepping address.
- R5: Control bits [4:0] choose the trigger. Values 0 to 23 select `req_in[n]`. Value 24 selects the software bit, which fires when control bit 9 is written as 1. Values 25 to 31 never trigger. A disabled channel ignores all triggers.
- R6: A channel keeps one pending flag. Triggers that arrive while it is set add no further transfers. The flag clears when that channel's transfer starts.
- R7: When both channels are pending while the port is idle, channel 0 is served first.
- R8: A write to the fixed-side address changes the working address immediately. Writes to the stepping-side address and to the count only reach the working copies at the next reload. Which side is fixed follows the mode held at the time of the write.
- R9: Writing control bit 8 from 0 to 1 reloads the working count and the stepping address. Writing 1 while the channel is already enabled does not reload.
- R10: Register address bit 2 picks the channel. Bits [1:0] pick source (0), destination (1), count (2) or control (3). The address and count registers read back the last value written, at any time, with all 24 address bits kept; only the low 20 drive the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: channel in bit 2, register in bits 1:0 |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data for `reg_addr` |
| req_in | input | 24 | Peripheral trigger pulses |
| bus_req | output | 1 | Memory cycle request |
| bus_we | output | 1 | 1 for the write cycle, 0 for the read cycle |
| bus_addr | output | 20 | Memory address |
| bus_wide | output | 1 | 1 for a 16-bit unit, 0 for a byte |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` on a read |
| bus_ack | input | 1 | Completes the current cycle |
| irq | output | 2 | One-cycle end-of-block pulse per channel |

## Verification
The hardest case to reach is a second trigger landing while a channel's request is already pending. From outside, that only happens when the other channel holds the bus. The stimulus slows the memory acknowledge to several cycles and starts a software transfer on channel 0. While that transfer is in flight, it pulses channel 1's peripheral line three times. Exactly one channel 1 transfer must follow. Underflow that coincides with a pending reload-register write is reached by random register writes between random triggers, checked against a bench model of the working and reload copies.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    typedef enum logic [1:0] {
        MD_FIXED = 2'd0,
        MD_SRC   = 2'd1,
        MD_DST   = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        RG_SRC  = 2'd0,
        RG_DST  = 2'd1,
        RG_CNT  = 2'd2,
        RG_CTRL = 2'd3
    } reg_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } bus_st_e;

endpackage

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int AW   = 20,
    parameter int RW   = 24,
    parameter int CW   = 16,
    parameter int NREQ = 24,
    parameter int SELW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  reg_e            idx,
    input  logic [RW-1:0]   wdata,
    output logic [RW-1:0]   rdata,
    input  logic [NREQ-1:0] req_in,
    input  logic            start,
    input  logic            done,
    output logic            pend,
    output logic [AW-1:0]   src,
    output logic [AW-1:0]   dst,
    output logic            wide,
    output logic            irq
);
    localparam int TV     = 1 << SELW;
    localparam int P_WIDE = SELW;
    localparam int P_MODE = SELW + 1;
    localparam int P_EN   = SELW + 3;
    localparam int P_SW   = SELW + 4;

    typedef struct packed {
        logic [RW-1:0]   src_rld;
        logic [RW-1:0]   dst_rld;
        logic [CW-1:0]   cnt_rld;
        logic [AW-1:0]   src_w;
        logic [AW-1:0]   dst_w;
        logic [CW-1:0]   cnt_w;
        logic [SELW-1:0] sel;
        logic            wide;
        mode_e           mode;
        logic            en;
        logic            pend;
        logic            irq;
    } ch_s;

    ch_s ch_d, ch_q;

    always_comb begin
        logic [AW-1:0] step;
        logic [TV-1:0] trig_vec;
        logic          reload;
        logic          en_rise;
        logic          sw;

        ch_d     = ch_q;
        ch_d.irq = 1'b0;
        reload   = 1'b0;
        en_rise  = 1'b0;
        sw       = 1'b0;
        step     = ch_q.wide ? AW'(2) : AW'(1);

        // unit completed: count down and step, or underflow
        if (done) begin
            if (ch_q.cnt_w == '0) begin
                ch_d.irq = 1'b1;
                reload   = 1'b1;
            end else begin
                ch_d.cnt_w = ch_q.cnt_w - 1'b1;
                if (ch_q.mode == MD_SRC) ch_d.src_w = ch_q.src_w + step;
                if (ch_q.mode == MD_DST) ch_d.dst_w = ch_q.dst_w + step;
            end
        end

        // CPU writes
        if (wr_en) begin
            case (idx)
                RG_SRC: begin
                    ch_d.src_rld = wdata;
                    if (ch_q.mode != MD_SRC) ch_d.src_w = wdata[AW-1:0];
                end
                RG_DST: begin
                    ch_d.dst_rld = wdata;
                    if (ch_q.mode != MD_DST) ch_d.dst_w = wdata[AW-1:0];
                end
                RG_CNT: ch_d.cnt_rld = wdata[CW-1:0];
                default: begin
                    ch_d.sel  = wdata[SELW-1:0];
                    ch_d.wide = wdata[P_WIDE];
                    case (wdata[P_MODE +: 2])
                        2'd1:    ch_d.mode = MD_SRC;
                        2'd2:    ch_d.mode = MD_DST;
                        default: ch_d.mode = MD_FIXED;
                    endcase
                    ch_d.en = wdata[P_EN];
                    en_rise = wdata[P_EN] & ~ch_q.en;
                    sw      = wdata[P_SW];
                end
            endcase
        end

        // reload of count and stepping side
        if (reload || en_rise) begin
            ch_d.cnt_w = ch_d.cnt_rld;
            if (ch_d.mode == MD_SRC) ch_d.src_w = ch_d.src_rld[AW-1:0];
            if (ch_d.mode == MD_DST) ch_d.dst_w = ch_d.dst_rld[AW-1:0];
        end

        // trigger select: lines, then software, then nothing
        trig_vec  = TV'({sw, req_in});
        ch_d.pend = ch_d.en & ((ch_q.pend & ~start) | trig_vec[ch_d.sel]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    always_comb begin
        rdata = '0;
        case (idx)
            RG_SRC: rdata = ch_q.src_rld;
            RG_DST: rdata = ch_q.dst_rld;
            RG_CNT: rdata = RW'(ch_q.cnt_rld);
            default: begin
                rdata[SELW-1:0]     = ch_q.sel;
                rdata[P_WIDE]       = ch_q.wide;
                rdata[P_MODE +: 2]  = ch_q.mode;
                rdata[P_EN]         = ch_q.en;
            end
        endcase
    end

    assign pend = ch_q.pend;
    assign src  = ch_q.src_w;
    assign dst  = ch_q.dst_w;
    assign wide = ch_q.wide;
    assign irq  = ch_q.irq;

endmodule

// File: rtl/dmac_arb.sv
module dmac_arb #(
    parameter int NCH = 2,
    parameter int IDW = 1
) (
    input  logic [NCH-1:0] pend,
    output logic           gnt_valid,
    output logic [IDW-1:0] gnt_id
);
    always_comb begin
        gnt_valid = |pend;
        gnt_id    = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) gnt_id = IDW'(i);
        end
    end
endmodule

// File: rtl/dmac_bus.sv
module dmac_bus
    import dmac_pkg::*;
#(
    parameter int AW  = 20,
    parameter int DW  = 16,
    parameter int IDW = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [IDW-1:0] go_id,
    input  logic [AW-1:0]  go_src,
    input  logic [AW-1:0]  go_dst,
    input  logic           go_wide,
    output logic           idle,
    output logic           done,
    output logic [IDW-1:0] done_id,
    output logic           bus_req,
    output logic           bus_we,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_wide,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    input  logic           bus_ack
);
    typedef struct packed {
        bus_st_e        st;
        logic [IDW-1:0] id;
        logic [AW-1:0]  src;
        logic [AW-1:0]  dst;
        logic           wide;
        logic [DW-1:0]  data;
    } bus_s;

    bus_s b_d, b_q;

    always_comb begin
        b_d = b_q;
        case (b_q.st)
            ST_IDLE: if (go) begin
                b_d.st   = ST_RD;
                b_d.id   = go_id;
                b_d.src  = go_src;
                b_d.dst  = go_dst;
                b_d.wide = go_wide;
            end
            ST_RD: if (bus_ack) begin
                b_d.st   = ST_WR;
                b_d.data = bus_rdata;
            end
            ST_WR: if (bus_ack) b_d.st = ST_IDLE;
            default: b_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign idle      = (b_q.st == ST_IDLE);
    assign done      = (b_q.st == ST_WR) & bus_ack;
    assign done_id   = b_q.id;
    assign bus_req   = (b_q.st != ST_IDLE);
    assign bus_we    = (b_q.st == ST_WR);
    assign bus_addr  = bus_we ? b_q.dst : b_q.src;
    assign bus_wide  = b_q.wide;
    assign bus_wdata = b_q.data;
endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int NCH  = 2,
    parameter int NREQ = 24,
    parameter int AW   = 20,
    parameter int RW   = 24,
    parameter int CW   = 16,
    parameter int DW   = 16,
    parameter int IDW  = $clog2(NCH),
    parameter int RAW  = IDW + 2,
    parameter int SELW = $clog2(NREQ + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [RW-1:0]   reg_wdata,
    output logic [RW-1:0]   reg_rdata,
    input  logic [NREQ-1:0] req_in,
    output logic            bus_req,
    output logic            bus_we,
    output logic [AW-1:0]   bus_addr,
    output logic            bus_wide,
    output logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata,
    input  logic            bus_ack,
    output logic [NCH-1:0]  irq
);
    logic [IDW-1:0] reg_ch;
    logic [NCH-1:0] pend_vec, start_vec, done_vec, wide_vec;
    logic [AW-1:0]  src_arr [NCH];
    logic [AW-1:0]  dst_arr [NCH];
    logic [RW-1:0]  rd_arr  [NCH];
    logic           gnt_valid, bus_idle, bus_done;
    logic [IDW-1:0] gnt_id, done_id;

    assign reg_ch = reg_addr[RAW-1:2];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign start_vec[g] = bus_idle & gnt_valid & (gnt_id == IDW'(g));
        assign done_vec[g]  = bus_done & (done_id == IDW'(g));

        dmac_channel #(
            .AW(AW), .RW(RW), .CW(CW), .NREQ(NREQ), .SELW(SELW)
        ) i_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (reg_wr & (reg_ch == IDW'(g))),
            .idx    (reg_e'(reg_addr[1:0])),
            .wdata  (reg_wdata),
            .rdata  (rd_arr[g]),
            .req_in (req_in),
            .start  (start_vec[g]),
            .done   (done_vec[g]),
            .pend   (pend_vec[g]),
            .src    (src_arr[g]),
            .dst    (dst_arr[g]),
            .wide   (wide_vec[g]),
            .irq    (irq[g])
        );
    end

    assign reg_rdata = rd_arr[reg_ch];

    dmac_arb #(.NCH(NCH), .IDW(IDW)) i_arb (
        .pend      (pend_vec),
        .gnt_valid (gnt_valid),
        .gnt_id    (gnt_id)
    );

    dmac_bus #(.AW(AW), .DW(DW), .IDW(IDW)) i_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (gnt_valid),
        .go_id     (gnt_id),
        .go_src    (src_arr[gnt_id]),
        .go_dst    (dst_arr[gnt_id]),
        .go_wide   (wide_vec[gnt_id]),
        .idle      (bus_idle),
        .done      (bus_done),
        .done_id   (done_id),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wide  (bus_wide),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack)
    );
endmodule

// File: rtl/dmac_chk.sv
module dmac_chk #(
    parameter int AW  = 20,
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_req,
    input logic           bus_ack,
    input logic           bus_we,
    input logic [AW-1:0]  bus_addr,
    input logic [NCH-1:0] irq,
    input logic [NCH-1:0] pend,
    input logic           idle,
    input logic [AW-1:0]  src0
);
    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    // R2
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && !bus_we) |=> (bus_req && bus_we));

    // R2
    wr_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_we) |=> !bus_req);

    // R4
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |-> $past(bus_req && bus_ack && bus_we));

    // R4
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |=> (irq == '0));

    // R7
    prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && pend[0]) |=> (bus_req && !bus_we && bus_addr == $past(src0)));
endmodule

bind dmac_top dmac_chk #(.AW(AW), .NCH(NCH)) i_dmac_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_ack  (bus_ack),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .irq      (irq),
    .pend     (pend_vec),
    .idle     (bus_idle),
    .src0     (src_arr[0])
);

// File: tb/test_dmac_top.sv
module test_dmac_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic [23:0] req_in = '0;
    logic        bus_req, bus_we, bus_wide;
    logic [19:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic [1:0]  irq;

    dmac_top i_dmac_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_in(req_in),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .irq(irq)
    );

    always #5 clk = ~clk;

    int n_checks = 0, n_err = 0;
    int fixed_delay = 0, rand_mode = 0, cur_delay = 0, wait_cnt = 0;
    int log_n = 0, cursor = 0;
    logic [19:0] log_src [512];
    logic [19:0] log_dst [512];
    logic [19:0] rd_addr = '0;
    int irq_cnt [2] = '{0, 0};
    int exp_irq [2] = '{0, 0};

    // bench model of the programming and working state
    logic [23:0] r_src [2] = '{0, 0};
    logic [23:0] r_dst [2] = '{0, 0};
    logic [15:0] r_cnt [2] = '{0, 0};
    logic [15:0] m_cnt [2] = '{0, 0};
    logic [19:0] m_src [2] = '{0, 0};
    logic [19:0] m_dst [2] = '{0, 0};
    logic [1:0]  m_mode [2] = '{0, 0};
    logic        m_wide [2] = '{0, 0};
    logic        m_en [2] = '{0, 0};
    logic [4:0]  m_sel [2] = '{0, 0};

    function automatic logic [15:0] pat(input logic [19:0] a);
        return {a[7:0] ^ 8'h5A, a[15:8] ^ {a[19:16], 4'h3}};
    endfunction

    function automatic logic [19:0] step_addr(input logic [19:0] a, input logic w);
        return a + (w ? 20'd2 : 20'd1);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack  = 1'b0;
                wait_cnt = 0;
            end else if (rst_n && bus_req) begin
                if (wait_cnt >= cur_delay) begin
                    bus_ack = 1'b1;
                    if (!bus_we) begin
                        rd_addr   = bus_addr;
                        bus_rdata = pat(bus_addr);
                    end else begin
                        check("R2", "write data", 32'(bus_wdata), 32'(pat(rd_addr)));
                        log_src[log_n % 512] = rd_addr;
                        log_dst[log_n % 512] = bus_addr;
                        log_n++;
                    end
                    cur_delay = (rand_mode != 0) ? int'($urandom_range(0, 3)) : fixed_delay;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            for (int c = 0; c < 2; c++) if (irq[c]) irq_cnt[c]++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    task automatic raw_wr(input int ch, input int idx, input logic [23:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = 3'(ch * 4 + idx);
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd_reg(input int ch, input int idx, output logic [23:0] v);
        @(negedge clk);
        reg_addr = 3'(ch * 4 + idx);
        #1;
        v = reg_rdata;
    endtask

    task automatic model_reload(input int ch);
        m_cnt[ch] = r_cnt[ch];
        if (m_mode[ch] == 2'd1) m_src[ch] = r_src[ch][19:0];
        if (m_mode[ch] == 2'd2) m_dst[ch] = r_dst[ch][19:0];
    endtask

    // address / count registers: R8 rules in the model
    task automatic set_reg(input int ch, input int idx, input logic [23:0] d);
        if (idx == 0) begin
            r_src[ch] = d;
            if (m_mode[ch] != 2'd1) m_src[ch] = d[19:0];
        end else if (idx == 1) begin
            r_dst[ch] = d;
            if (m_mode[ch] != 2'd2) m_dst[ch] = d[19:0];
        end else begin
            r_cnt[ch] = d[15:0];
        end
        raw_wr(ch, idx, d);
    endtask

    task automatic wr_ctrl(input int ch, input int sel, input logic wide,
                           input int mode, input logic en, input logic sw);
        logic old_en;
        old_en      = m_en[ch];
        m_sel[ch]   = 5'(sel);
        m_wide[ch]  = wide;
        m_mode[ch]  = (mode == 3) ? 2'd0 : 2'(mode);
        m_en[ch]    = en;
        if (en && !old_en) model_reload(ch);
        raw_wr(ch, 3, {14'd0, sw, en, 2'(mode), wide, 5'(sel)});
    endtask

    task automatic trig_sw(input int ch);
        wr_ctrl(ch, int'(m_sel[ch]), m_wide[ch], int'(m_mode[ch]), m_en[ch], 1'b1);
    endtask

    task automatic pulse(input int b);
        @(negedge clk);
        req_in[b] = 1'b1;
        @(negedge clk);
        req_in[b] = 1'b0;
    endtask

    task automatic expect_xfer(input int ch, input string req);
        int t = 0;
        while (log_n <= cursor && t < 400) begin
            @(negedge clk);
            t++;
        end
        check(req, "source address", 32'(log_src[cursor % 512]), 32'(m_src[ch]));
        check(req, "destination address", 32'(log_dst[cursor % 512]), 32'(m_dst[ch]));
        cursor++;
        if (m_cnt[ch] == 16'd0) begin
            exp_irq[ch]++;
            model_reload(ch);
        end else begin
            m_cnt[ch] = m_cnt[ch] - 16'd1;
            if (m_mode[ch] == 2'd1) m_src[ch] = step_addr(m_src[ch], m_wide[ch]);
            if (m_mode[ch] == 2'd2) m_dst[ch] = step_addr(m_dst[ch], m_wide[ch]);
        end
        repeat (3) @(negedge clk);
        check("R4", "interrupt count", 32'(irq_cnt[ch]), 32'(exp_irq[ch]));
    endtask

    task automatic no_xfer(input int cycles, input string req);
        int n0 = log_n;
        repeat (cycles) @(negedge clk);
        check(req, "no transfer", 32'(log_n), 32'(n0));
    endtask

    initial begin
        logic [23:0] v;
        void'($urandom(32'd7031));

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", "bus_req", 32'(bus_req), 0);
        check("R1", "irq", 32'(irq), 0);
        for (int ch = 0; ch < 2; ch++)
            for (int i = 0; i < 4; i++) begin
                rd_reg(ch, i, v);
                check("R1", "register after reset", 32'(v), 0);
            end

        // R10 readback of reload registers
        set_reg(1, 0, 24'hABCDEF);
        set_reg(1, 2, 24'h001234);
        rd_reg(1, 0, v); check("R10", "source readback", 32'(v), 32'h00ABCDEF);
        rd_reg(1, 2, v); check("R10", "count readback", 32'(v), 32'h00001234);

        // R3 R4 R5: channel 0 stepping source, bytes, block of 3
        wr_ctrl(0, 24, 1'b0, 1, 1'b0, 1'b0);
        set_reg(0, 0, 24'h001000);
        set_reg(0, 1, 24'h020000);
        set_reg(0, 2, 24'd2);
        wr_ctrl(0, 24, 1'b0, 1, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) begin
            trig_sw(0);
            expect_xfer(0, "R3");
        end
        check("R4", "src after wrap of block", 32'(log_src[3]), 32'h01000);
        check("R4", "irq after third unit", 32'(irq_cnt[0]), 1);

        // R3: mode 3 stored as 0, both addresses fixed
        wr_ctrl(0, 24, 1'b0, 3, 1'b1, 1'b0);
        rd_reg(0, 3, v);
        check("R3", "mode 3 reads back", 32'(v[7:6]), 0);
        trig_sw(0); expect_xfer(0, "R3");
        trig_sw(0); expect_xfer(0, "R3");

        // R3: 16-bit stepping destination wraps in 20 bits
        wr_ctrl(1, 24, 1'b1, 2, 1'b0, 1'b0);
        set_reg(1, 0, 24'h000300);
        set_reg(1, 1, 24'h0FFFFE);
        set_reg(1, 2, 24'd5);
        wr_ctrl(1, 24, 1'b1, 2, 1'b1, 1'b0);
        trig_sw(1); expect_xfer(1, "R3");
        trig_sw(1); expect_xfer(1, "R3");
        check("R3", "wrapped destination", 32'(log_dst[(cursor - 1) % 512]), 0);

        // R5: disabled channel and empty selects ignore triggers
        wr_ctrl(0, 24, 1'b0, 1, 1'b0, 1'b0);
        wr_ctrl(0, 24, 1'b0, 1, 1'b0, 1'b1);
        no_xfer(20, "R5");
        wr_ctrl(0, 31, 1'b0, 1, 1'b1, 1'b1);
        no_xfer(20, "R5");

        // R7: one line feeds both channels, channel 0 first
        wr_ctrl(0, 7, 1'b0, 1, 1'b1, 1'b0);
        wr_ctrl(1, 7, 1'b1, 2, 1'b1, 1'b0);
        pulse(7);
        expect_xfer(0, "R7");
        expect_xfer(1, "R7");
        pulse(8);
        no_xfer(20, "R5");

        // R6: repeated triggers while pending count once
        wr_ctrl(0, 24, 1'b0, 1, 1'b1, 1'b0);
        fixed_delay = 8;
        cur_delay   = 8;
        trig_sw(0);
        repeat (2) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            pulse(7);
            @(negedge clk);
        end
        expect_xfer(0, "R6");
        expect_xfer(1, "R6");
        no_xfer(40, "R6");
        fixed_delay = 0;
        cur_delay   = 0;

        // R8 R9: fixed-side writes now, stepping-side writes at reload
        wr_ctrl(0, 24, 1'b1, 2, 1'b1, 1'b0);
        set_reg(0, 0, 24'h004444);
        trig_sw(0); expect_xfer(0, "R8");
        check("R8", "fixed source used at once", 32'(log_src[(cursor - 1) % 512]), 32'h04444);
        set_reg(0, 1, 24'h008000);
        set_reg(0, 2, 24'd9);
        trig_sw(0); expect_xfer(0, "R8");
        wr_ctrl(0, 24, 1'b1, 2, 1'b0, 1'b0);
        wr_ctrl(0, 24, 1'b1, 2, 1'b1, 1'b0);
        trig_sw(0); expect_xfer(0, "R9");
        check("R9", "reloaded destination", 32'(log_dst[(cursor - 1) % 512]), 32'h08000);
        trig_sw(0); expect_xfer(0, "R9");
        check("R9", "no reload while enabled", 32'(log_dst[(cursor - 1) % 512]), 32'h08002);
        rd_reg(0, 1, v); check("R10", "destination readback", 32'(v), 32'h008000);

        // random rounds
        rand_mode = 1;
        for (int r = 0; r < 8; r++) begin
            int ch = int'($urandom_range(0, 1));
            int md = int'($urandom_range(0, 3));
            logic wd = 1'($urandom_range(0, 1));
            wr_ctrl(ch, 24, wd, md, 1'b0, 1'b0);
            set_reg(ch, 0, 24'($urandom));
            set_reg(ch, 1, 24'($urandom));
            set_reg(ch, 2, 24'($urandom_range(0, 4)));
            wr_ctrl(ch, 24, wd, md, 1'b1, 1'b0);
            for (int k = 0; k < int'($urandom_range(4, 12)); k++) begin
                if ($urandom_range(0, 3) == 0)
                    set_reg(ch, int'($urandom_range(0, 2)), 24'($urandom_range(0, 24'hFFFFF)));
                trig_sw(ch);
                expect_xfer(ch, "R8");
            end
            rd_reg(ch, 0, v); check("R10", "random source readback", 32'(v), 32'(r_src[ch]));
        end

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule